// File: doc/BRIEF.md
# Timestamped Traffic Counter Bank

This block keeps a fixed set of event counters for a packet-processing port. The datapath raises single-cycle strobes when a packet arrives from or leaves toward the line, when a packet crosses to or from one of eight switch ports, when a packet is passed to or returned from the embedded processor, and when one of several drop conditions occurs. Each strobe adds one to its own counter.

A control agent reads a counter by raising a read request with a 7-bit counter number. One cycle later the block presents the counter's value together with a free-running cycle timestamp. Both are captured by the same clock edge, so software can divide the difference of two readings by the difference of their timestamps to get a rate. Counter numbers that are not assigned read as zero.

Top module: `tstamp_ctr_bank`

## Requirements
- R1: After reset every counter is zero, `rd_vld` is low, `rd_value` and `rd_stamp` are zero, and the timestamp starts at zero.
- R2: The timestamp is a TS_W-bit (default 32) count that increases by one on every clock after reset is released and wraps at its width.
- R3: A read request sampled on a clock edge makes `rd_vld` high for exactly the following cycle; `rd_value` and `rd_stamp` keep their values until the next request.
- R4: Counter number 0 counts `link_in` strobes; counter number 16 counts `link_out` strobes.
- R5: A strobe on `ing_vld` with binary port number p on `ing_port` (p = 0..7) counts in counter 4+p; a strobe on `egr_vld` with port p counts in counter 20+p.
- R6: Counters 12 and 13 count packets arriving from the processor on the ingress and egress sides (`cpu_in_ing`, `cpu_in_egr`); counters 28 and 29 count packets sent to it on those sides (`cpu_out_ing`, `cpu_out_egr`).
- R7: Counter 64 counts dropped input cells, 65 invalid packets, and 66, 67, 68 queue drops for the line, switch and processor queues respectively.
- R8: A read of any counter number outside the sets in R4 to R7 returns value zero, and strobes never change what such a number reads.
- R9: A strobe in the same cycle as a read request of its counter is excluded from that read and appears in the next read.
- R10: Each strobe adds exactly one to its counter, modulo 2^CNT_W; strobes to different counters in the same cycle each take effect.
- R11: `rd_stamp` equals the timestamp value in the cycle the request was made, paired with the value captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_in | input | 1 | Packet received from the line |
| link_out | input | 1 | Packet sent to the line |
| ing_vld | input | 1 | Packet received from a switch port |
| ing_port | input | 3 | Switch port number for `ing_vld` |
| egr_vld | input | 1 | Packet sent to a switch port |
| egr_port | input | 3 | Switch port number for `egr_vld` |
| cpu_in_ing | input | 1 | Ingress-side packet from the processor |
| cpu_in_egr | input | 1 | Egress-side packet from the processor |
| cpu_out_ing | input | 1 | Ingress-side packet to the processor |
| cpu_out_egr | input | 1 | Egress-side packet to the processor |
| cell_drop | input | 1 | Input cell dropped |
| bad_pkt | input | 1 | Invalid packet discarded |
| qdrop_link | input | 1 | Line queue drop |
| qdrop_switch | input | 1 | Switch queue drop |
| qdrop_cpu | input | 1 | Processor queue drop |
| rd_req | input | 1 | Read request |
| rd_idx | input | 7 | Counter number to read |
| rd_vld | output | 1 | Read response valid |
| rd_value | output | CNT_W | Captured counter value |
| rd_stamp | output | TS_W | Timestamp captured with the value |

## Verification
The hardest situation to reach is a strobe landing on the very edge that samples a read of the same counter, where a wrong design could return a half-updated or already-incremented value. The stimulus raises the drop strobe and the read request in the same cycle, expects the pre-strobe count, and reads again to see the strobe included. Counter wrap is reached by building the bench with a narrow counter width and issuing enough strobes to pass the top of the range.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int NUM_PORTS = 8;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int IDX_W     = 7;

  // physical slot layout; the counter numbers software sees come from slot_to_index
  localparam int S_LINK_IN   = 0;
  localparam int S_LINK_OUT  = 1;
  localparam int S_ING0      = 2;
  localparam int S_EGR0      = S_ING0 + NUM_PORTS;
  localparam int S_CPU_IN_I  = S_EGR0 + NUM_PORTS;
  localparam int S_CPU_IN_E  = S_CPU_IN_I + 1;
  localparam int S_CPU_OUT_I = S_CPU_IN_I + 2;
  localparam int S_CPU_OUT_E = S_CPU_IN_I + 3;
  localparam int S_CELL_DROP = S_CPU_IN_I + 4;
  localparam int S_BAD_PKT   = S_CPU_IN_I + 5;
  localparam int S_QD_LINK   = S_CPU_IN_I + 6;
  localparam int S_QD_SW     = S_CPU_IN_I + 7;
  localparam int S_QD_CPU    = S_CPU_IN_I + 8;
  localparam int NUM_SLOTS   = S_QD_CPU + 1;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);

  // software-visible counter numbers
  localparam int N_LINK_IN   = 0;
  localparam int N_ING_BASE  = 4;
  localparam int N_CPU_IN_I  = 12;
  localparam int N_CPU_IN_E  = 13;
  localparam int N_LINK_OUT  = 16;
  localparam int N_EGR_BASE  = 20;
  localparam int N_CPU_OUT_I = 28;
  localparam int N_CPU_OUT_E = 29;
  localparam int N_DROP_BASE = 64;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_lookup_t;

  function automatic logic [IDX_W-1:0] slot_to_index(input int slot);
    int n;
    if (slot == S_LINK_IN)                                n = N_LINK_IN;
    else if (slot == S_LINK_OUT)                          n = N_LINK_OUT;
    else if (slot >= S_ING0 && slot < S_EGR0)             n = N_ING_BASE + (slot - S_ING0);
    else if (slot >= S_EGR0 && slot < S_CPU_IN_I)         n = N_EGR_BASE + (slot - S_EGR0);
    else if (slot == S_CPU_IN_I)                          n = N_CPU_IN_I;
    else if (slot == S_CPU_IN_E)                          n = N_CPU_IN_E;
    else if (slot == S_CPU_OUT_I)                         n = N_CPU_OUT_I;
    else if (slot == S_CPU_OUT_E)                         n = N_CPU_OUT_E;
    else                                                  n = N_DROP_BASE + (slot - S_CELL_DROP);
    return IDX_W'(n);
  endfunction

  function automatic slot_lookup_t index_to_slot(input logic [IDX_W-1:0] idx);
    slot_lookup_t r;
    r = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_to_index(s) == idx) begin
        r.hit  = 1'b1;
        r.slot = SLOT_W'(s);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tsc_timebase.sv
module tsc_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);

  function automatic logic [TS_W-1:0] tick(input logic [TS_W-1:0] t);
    return t + TS_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= tick(ts);
  end

endmodule

// File: rtl/tsc_event_map.sv
module tsc_event_map
  import tsc_pkg::*;
(
  input  logic                 link_in,
  input  logic                 link_out,
  input  logic                 ing_vld,
  input  logic [PORT_W-1:0]    ing_port,
  input  logic                 egr_vld,
  input  logic [PORT_W-1:0]    egr_port,
  input  logic                 cpu_in_ing,
  input  logic                 cpu_in_egr,
  input  logic                 cpu_out_ing,
  input  logic                 cpu_out_egr,
  input  logic                 cell_drop,
  input  logic                 bad_pkt,
  input  logic                 qdrop_link,
  input  logic                 qdrop_switch,
  input  logic                 qdrop_cpu,
  output logic [NUM_SLOTS-1:0] slot_inc
);

  always_comb begin
    slot_inc = '0;
    slot_inc[S_LINK_IN]   = link_in;
    slot_inc[S_LINK_OUT]  = link_out;
    for (int p = 0; p < NUM_PORTS; p++) begin
      slot_inc[S_ING0 + p] = ing_vld && (ing_port == PORT_W'(p));
      slot_inc[S_EGR0 + p] = egr_vld && (egr_port == PORT_W'(p));
    end
    slot_inc[S_CPU_IN_I]  = cpu_in_ing;
    slot_inc[S_CPU_IN_E]  = cpu_in_egr;
    slot_inc[S_CPU_OUT_I] = cpu_out_ing;
    slot_inc[S_CPU_OUT_E] = cpu_out_egr;
    slot_inc[S_CELL_DROP] = cell_drop;
    slot_inc[S_BAD_PKT]   = bad_pkt;
    slot_inc[S_QD_LINK]   = qdrop_link;
    slot_inc[S_QD_SW]     = qdrop_switch;
    slot_inc[S_QD_CPU]    = qdrop_cpu;
  end

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (inc) q <= bump(q);
  end

endmodule

// File: rtl/tsc_read_port.sv
module tsc_read_port
  import tsc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic [NUM_SLOTS*CNT_W-1:0] cnt_flat,
  input  logic [TS_W-1:0]            ts_now,
  output logic                       idx_hit,
  output logic                       rd_vld,
  output logic [CNT_W-1:0]           rd_value,
  output logic [TS_W-1:0]            rd_stamp
);

  slot_lookup_t     lk;
  logic [CNT_W-1:0] sel_value;

  always_comb begin
    lk        = index_to_slot(rd_idx);
    idx_hit   = lk.hit;
    sel_value = '0;
    if (lk.hit) sel_value = cnt_flat[int'(lk.slot)*CNT_W +: CNT_W];
  end

  // value and stamp share one enable so they come from the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld   <= 1'b0;
      rd_value <= '0;
      rd_stamp <= '0;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) begin
        rd_value <= sel_value;
        rd_stamp <= ts_now;
      end
    end
  end

endmodule

// File: rtl/tstamp_ctr_bank.sv
module tstamp_ctr_bank
  import tsc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_in,
  input  logic              link_out,
  input  logic              ing_vld,
  input  logic [2:0]        ing_port,
  input  logic              egr_vld,
  input  logic [2:0]        egr_port,
  input  logic              cpu_in_ing,
  input  logic              cpu_in_egr,
  input  logic              cpu_out_ing,
  input  logic              cpu_out_egr,
  input  logic              cell_drop,
  input  logic              bad_pkt,
  input  logic              qdrop_link,
  input  logic              qdrop_switch,
  input  logic              qdrop_cpu,
  input  logic              rd_req,
  input  logic [6:0]        rd_idx,
  output logic              rd_vld,
  output logic [CNT_W-1:0]  rd_value,
  output logic [TS_W-1:0]   rd_stamp
);

  localparam int FLAT_W = NUM_SLOTS * CNT_W;

  // named internal events, also observed by the checker
  logic [NUM_SLOTS-1:0] slot_inc;
  logic [FLAT_W-1:0]    cnt_flat;
  logic [TS_W-1:0]      ts_now;
  logic                 idx_hit;

  tsc_timebase #(.TS_W(TS_W)) u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .ts    (ts_now)
  );

  tsc_event_map u_map (
    .link_in      (link_in),
    .link_out     (link_out),
    .ing_vld      (ing_vld),
    .ing_port     (ing_port),
    .egr_vld      (egr_vld),
    .egr_port     (egr_port),
    .cpu_in_ing   (cpu_in_ing),
    .cpu_in_egr   (cpu_in_egr),
    .cpu_out_ing  (cpu_out_ing),
    .cpu_out_egr  (cpu_out_egr),
    .cell_drop    (cell_drop),
    .bad_pkt      (bad_pkt),
    .qdrop_link   (qdrop_link),
    .qdrop_switch (qdrop_switch),
    .qdrop_cpu    (qdrop_cpu),
    .slot_inc     (slot_inc)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cnt
    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (slot_inc[s]),
      .q     (cnt_flat[s*CNT_W +: CNT_W])
    );
  end

  tsc_read_port #(.CNT_W(CNT_W), .TS_W(TS_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_idx   (rd_idx),
    .cnt_flat (cnt_flat),
    .ts_now   (ts_now),
    .idx_hit  (idx_hit),
    .rd_vld   (rd_vld),
    .rd_value (rd_value),
    .rd_stamp (rd_stamp)
  );

endmodule

// File: rtl/tsc_chk.sv
module tsc_chk
  import tsc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_req,
  input logic                       rd_vld,
  input logic [CNT_W-1:0]           rd_value,
  input logic [TS_W-1:0]            rd_stamp,
  input logic [TS_W-1:0]            ts_now,
  input logic                       idx_hit,
  input logic [NUM_SLOTS-1:0]       slot_inc,
  input logic [NUM_SLOTS*CNT_W-1:0] cnt_flat
);

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts_now == $past(ts_now) + TS_W'(1));

  // R3
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld);

  // R3
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_vld);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> ($stable(rd_value) && $stable(rd_stamp)));

  // R8
  unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !idx_hit) |=> rd_value == '0);

  // R11
  stamp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_stamp == $past(ts_now));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // R10
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_inc[s] |=> cnt_flat[s*CNT_W +: CNT_W] == $past(cnt_flat[s*CNT_W +: CNT_W]) + CNT_W'(1));
    // R10
    slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_inc[s] |=> $stable(cnt_flat[s*CNT_W +: CNT_W]));
  end

endmodule

bind tstamp_ctr_bank tsc_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_vld   (rd_vld),
  .rd_value (rd_value),
  .rd_stamp (rd_stamp),
  .ts_now   (ts_now),
  .idx_hit  (idx_hit),
  .slot_inc (slot_inc),
  .cnt_flat (cnt_flat)
);

// File: tb/tstamp_ctr_bank_tb.sv
module tstamp_ctr_bank_tb;

  localparam int CW = 8;   // narrow counters so wrap is reachable
  localparam int TW = 32;
  localparam int NV = 19;

  // {kind[3:0], port[2:0], reps[3:0], read index[6:0], expected[7:0]}
  // kind: 0 link_in 1 link_out 2 ing 3 egr 4 cpu_in_ing 5 cpu_in_egr
  //       6 cpu_out_ing 7 cpu_out_egr 8 cell_drop 9 bad_pkt
  //       10 qdrop_link 11 qdrop_switch 12 qdrop_cpu 15 none
  localparam logic [25:0] VEC [0:NV-1] = '{
    {4'd0,  3'd0, 4'd3, 7'd0,   8'd3},
    {4'd1,  3'd0, 4'd2, 7'd16,  8'd2},
    {4'd2,  3'd0, 4'd1, 7'd4,   8'd1},
    {4'd2,  3'd7, 4'd4, 7'd11,  8'd4},
    {4'd3,  3'd3, 4'd2, 7'd23,  8'd2},
    {4'd3,  3'd7, 4'd1, 7'd27,  8'd1},
    {4'd4,  3'd0, 4'd1, 7'd12,  8'd1},
    {4'd5,  3'd0, 4'd2, 7'd13,  8'd2},
    {4'd6,  3'd0, 4'd3, 7'd28,  8'd3},
    {4'd7,  3'd0, 4'd1, 7'd29,  8'd1},
    {4'd8,  3'd0, 4'd2, 7'd64,  8'd2},
    {4'd9,  3'd0, 4'd1, 7'd65,  8'd1},
    {4'd10, 3'd0, 4'd3, 7'd66,  8'd3},
    {4'd11, 3'd0, 4'd1, 7'd67,  8'd1},
    {4'd12, 3'd0, 4'd2, 7'd68,  8'd2},
    {4'd0,  3'd0, 4'd1, 7'd1,   8'd0},
    {4'd2,  3'd1, 4'd2, 7'd5,   8'd2},
    {4'd15, 3'd0, 4'd0, 7'd0,   8'd4},
    {4'd15, 3'd0, 4'd0, 7'd127, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_in = 0, link_out = 0, ing_vld = 0, egr_vld = 0;
  logic [2:0] ing_port = '0, egr_port = '0;
  logic cpu_in_ing = 0, cpu_in_egr = 0, cpu_out_ing = 0, cpu_out_egr = 0;
  logic cell_drop = 0, bad_pkt = 0, qdrop_link = 0, qdrop_switch = 0, qdrop_cpu = 0;
  logic rd_req = 0;
  logic [6:0] rd_idx = '0;
  logic rd_vld;
  logic [CW-1:0] rd_value;
  logic [TW-1:0] rd_stamp;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [TW-1:0] tb_cyc;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cyc <= '0;
    else        tb_cyc <= tb_cyc + 1;
  end

  tstamp_ctr_bank #(.CNT_W(CW), .TS_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .link_in(link_in), .link_out(link_out),
    .ing_vld(ing_vld), .ing_port(ing_port),
    .egr_vld(egr_vld), .egr_port(egr_port),
    .cpu_in_ing(cpu_in_ing), .cpu_in_egr(cpu_in_egr),
    .cpu_out_ing(cpu_out_ing), .cpu_out_egr(cpu_out_egr),
    .cell_drop(cell_drop), .bad_pkt(bad_pkt),
    .qdrop_link(qdrop_link), .qdrop_switch(qdrop_switch), .qdrop_cpu(qdrop_cpu),
    .rd_req(rd_req), .rd_idx(rd_idx),
    .rd_vld(rd_vld), .rd_value(rd_value), .rd_stamp(rd_stamp)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input int idx);
    if (idx == 0 || idx == 16)                          return "R4";
    if ((idx >= 4 && idx <= 11) || (idx >= 20 && idx <= 27)) return "R5";
    if (idx == 12 || idx == 13 || idx == 28 || idx == 29)    return "R6";
    if (idx >= 64 && idx <= 68)                          return "R7";
    return "R8";
  endfunction

  task automatic clear_ev();
    link_in = 0; link_out = 0; ing_vld = 0; egr_vld = 0;
    cpu_in_ing = 0; cpu_in_egr = 0; cpu_out_ing = 0; cpu_out_egr = 0;
    cell_drop = 0; bad_pkt = 0; qdrop_link = 0; qdrop_switch = 0; qdrop_cpu = 0;
  endtask

  task automatic set_ev(input int kind, input int port);
    case (kind)
      0:  link_in = 1;
      1:  link_out = 1;
      2:  begin ing_vld = 1; ing_port = 3'(port); end
      3:  begin egr_vld = 1; egr_port = 3'(port); end
      4:  cpu_in_ing = 1;
      5:  cpu_in_egr = 1;
      6:  cpu_out_ing = 1;
      7:  cpu_out_egr = 1;
      8:  cell_drop = 1;
      9:  bad_pkt = 1;
      10: qdrop_link = 1;
      11: qdrop_switch = 1;
      12: qdrop_cpu = 1;
      default: ;
    endcase
  endtask

  // called at a negedge; returns at a negedge
  task automatic pulse(input int kind, input int port, input int reps);
    for (int i = 0; i < reps; i++) begin
      set_ev(kind, port);
      @(posedge clk);
      @(negedge clk);
      clear_ev();
    end
  endtask

  task automatic do_read(input int idx, output logic [CW-1:0] v,
                         output logic [TW-1:0] st, output logic [TW-1:0] exp_st,
                         output logic vld);
    rd_req = 1; rd_idx = 7'(idx);
    exp_st = tb_cyc;
    @(posedge clk);
    @(negedge clk);
    rd_req = 0;
    v = rd_value; st = rd_stamp; vld = rd_vld;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    logic [TW-1:0] st, est, st1;
    logic vld;

    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1 vld in reset", rd_vld, 0);
    check("R1 value in reset", rd_value, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 vld idle", rd_vld, 0);
    do_read(0, v, st, est, vld);
    check("R1 counter zero", v, 0);
    check("R1 stamp from zero", st, est);
    check("R3 vld high", vld, 1);
    @(negedge clk);
    check("R3 vld one cycle", rd_vld, 0);
    check("R3 stamp held", rd_stamp, est);

    // table walk
    for (int k = 0; k < NV; k++) begin
      int kind, port, reps, idx, expv;
      kind = int'(VEC[k][25:22]);
      port = int'(VEC[k][21:19]);
      reps = int'(VEC[k][18:15]);
      idx  = int'(VEC[k][14:8]);
      expv = int'(VEC[k][7:0]);
      pulse(kind, port, reps);
      do_read(idx, v, st, est, vld);
      check(req_of(idx), v, expv);
      check("R11 stamp", st, est);
    end

    // R2 timestamp spacing
    do_read(4, v, st1, est, vld);
    repeat (7) @(negedge clk);
    do_read(4, v, st, est, vld);
    check("R2 stamp delta", st - st1, 8);

    // R9 strobe coincides with read of same counter (64 holds 2)
    cell_drop = 1;
    do_read(64, v, st, est, vld);
    cell_drop = 0;
    check("R9 excluded", v, 2);
    do_read(64, v, st, est, vld);
    check("R9 next read", v, 3);

    // R10 simultaneous strobes to different counters
    set_ev(2, 2); set_ev(3, 2); set_ev(0, 0);
    @(posedge clk); @(negedge clk); clear_ev();
    do_read(6, v, st, est, vld);
    check("R10 ingress p2", v, 1);
    do_read(22, v, st, est, vld);
    check("R10 egress p2", v, 1);
    do_read(0, v, st, est, vld);
    check("R10 link in", v, 5);

    // R10 wrap: counter 67 holds 1
    pulse(11, 0, 255);
    do_read(67, v, st, est, vld);
    check("R10 wrap", v, 0);
    pulse(11, 0, 1);
    do_read(67, v, st, est, vld);
    check("R10 after wrap", v, 1);

    // R8 unassigned after many strobes
    do_read(69, v, st, est, vld);
    check("R8 idx 69", v, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule